// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog for a system controller. It has a 64-bit up-counter, a 64-bit period and a small register file on a 32-bit write/read bus. Arming takes several steps. Software first selects watchdog operation in a mode field. It then sets a one-way enable bit. Two fixed 16-bit keys, written in order into the upper half of the control register, move the block through a pre-active phase into the active phase. The counter advances only while the block is active.

Once active, the block expects each service to be the same pair of keys, written back to back. A correct pair returns the counter to zero. Two events raise the registered reset request:

- the counter becomes equal to the period;
- a control write breaks the key pair.

The request stays high until the block's own reset is applied. Counter and period words can be loaded only before the enable bit is set, so software clears or presets them first and then arms.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the reset request is low, the phase is 0 with the enable bit clear, and the counter, period and mode field all read zero.
- R2: While the phase is 0, the 32-bit words at offsets 0x10 (counter low), 0x14 (counter high), 0x18 (period low) and 0x1C (period high) can be written and read back. In any other phase, writes to these four words are ignored.
- R3: The mode field is at bits 3:2 of offset 0x24, and the value 2 selects watchdog operation. A control write that sets the enable bit while the mode differs from 2 leaves the phase at 0. Writes to the mode field are ignored once the phase is not 0.
- R4: The control register is at offset 0x28. Its key field is bits 31:16, its enable bit is bit 14, and bits 1:0 read back the phase (0 off, 1 enabled, 2 pre-active, 3 active). A control write with bit 14 set, in phase 0 with mode 2, moves the phase to 1, and the register then reads 0x00004001.
- R5: The enable bit cannot be cleared: a control write with bit 14 clear in phase 1 leaves the register reading 0x00004001.
- R6: In phase 1, a control write with bit 14 set and key 0xA5C6 moves the phase to 2. Any other key, or a write with bit 14 clear, leaves phase 1.
- R7: In phase 2, a control write with bit 14 set and key 0xDA7E moves the phase to 3. Any other key leaves phase 2.
- R8: The counter increases by one on each clock only while the phase is 3 and no reset request is pending. The carry passes from the low word into the high word. In phases 0 to 2 the counter holds its value.
- R9: In phase 3, when the counter equals the period, the reset request goes high on the next clock edge.
- R10: In phase 3, a control write of key 0xA5C6 followed directly by a control write of key 0xDA7E sets the counter to zero on the edge of the second write and does not raise the reset request.
- R11: In phase 3, a control write whose key breaks the pair raises the reset request on the edge of that write. This covers a first key other than 0xA5C6, and a second key other than 0xDA7E.
- R12: Once high, the reset request stays high and the counter stops, until the reset input is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdog_rst_req | output | 1 | Registered system reset request, sticky until rst_n |

## Verification
The assertions assume one register access per cycle. They also assume that the key value they inspect is the one on the data bus in the same cycle as a control write strobe. They rely on the counter changing only through its own increment, a service, or a load while the phase is 0, so no outside agent can touch it. The bench keeps to these assumptions in three ways:

- It drives one write per clock, always from the falling edge.
- It holds address and data stable across the rising edge.
- It applies the reset only through rst_n, never in the middle of a transfer.

// File: rtl/wdog_pkg.sv
// Shared types and register layout for the key-sequenced watchdog.
// Assumes a 32-bit data bus and a byte-addressed 6-bit offset space.
package wdog_pkg;

    typedef enum logic [2:0] {
        ST_OFF,     // not enabled
        ST_EN,      // enabled, waiting for the first arming key
        ST_PRE,     // pre-active, waiting for the second arming key
        ST_ACT,     // active, waiting for the first service key
        ST_SVC      // active, first service key seen
    } wd_state_t;

    localparam int OFS_CNT0 = 'h10;
    localparam int OFS_PRD0 = 'h18;
    localparam int OFS_MODE = 'h24;
    localparam int OFS_CTRL = 'h28;

    localparam int MODE_LSB = 2;
    localparam logic [1:0] MODE_WDOG = 2'd2;
    localparam int EN_BIT  = 14;
    localparam int KEY_LSB = 16;

    localparam logic [1:0] PH_OFF = 2'd0;
    localparam logic [1:0] PH_EN  = 2'd1;
    localparam logic [1:0] PH_PRE = 2'd2;
    localparam logic [1:0] PH_ACT = 2'd3;

    // Map an internal state onto the two-bit phase software sees.
    function automatic logic [1:0] phase_of(wd_state_t s);
        case (s)
            ST_OFF:  return PH_OFF;
            ST_EN:   return PH_EN;
            ST_PRE:  return PH_PRE;
            default: return PH_ACT;
        endcase
    endfunction

endpackage

// File: rtl/wdog_bank.sv
// Period and mode configuration storage.
// Writes are accepted only while cfg_open is high (phase 0); after that
// the period and mode are frozen until reset.
module wdog_bank #(
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              cfg_open,
    output logic [CNT_W-1:0]  period_q,
    output logic [1:0]        mode_q
);
    import wdog_pkg::*;

    localparam int NW = CNT_W / BUS_W;

    // One write port per period word.
    for (genvar w = 0; w < NW; w++) begin : g_prd
        logic hit;
        assign hit = wr && cfg_open && (addr == ADDR_W'(OFS_PRD0 + 4 * w));

        // Load this period word from the bus.
        always_ff @(posedge clk) begin
            if (!rst_n)
                period_q[w*BUS_W +: BUS_W] <= '0;
            else if (hit)
                period_q[w*BUS_W +: BUS_W] <= wdata;
        end
    end

    // Capture the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr && cfg_open && (addr == ADDR_W'(OFS_MODE)))
            mode_q <= wdata[MODE_LSB +: 2];
    end

endmodule

// File: rtl/wdog_tally.sv
// The 64-bit up-counter. Priority: clear, then word load, then increment.
// Word loads are accepted only while cfg_open is high. run and clr are
// already qualified by the caller.
module wdog_tally #(
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              cfg_open,
    input  logic              run,
    input  logic              clr,
    output logic [CNT_W-1:0]  count_q
);
    import wdog_pkg::*;

    localparam int NW = CNT_W / BUS_W;

    logic [NW-1:0]    load;
    logic [CNT_W-1:0] count_d;

    // Decode a load strobe for each counter word.
    for (genvar w = 0; w < NW; w++) begin : g_ld
        assign load[w] = wr && cfg_open && (addr == ADDR_W'(OFS_CNT0 + 4 * w));
    end

    // Work out the next counter value.
    always_comb begin
        count_d = count_q;
        if (run)
            count_d = count_q + CNT_W'(1);
        for (int w = 0; w < NW; w++)
            if (load[w])
                count_d[w*BUS_W +: BUS_W] = wdata;
        if (clr)
            count_d = '0;
    end

    // Hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

endmodule

// File: rtl/wdog_arm_fsm.sv
// Arming and service sequencer.
// Walks off -> enabled -> pre-active -> active on control writes, then
// checks that the service keys come as a pair. It flags a completed
// service and any key that breaks the pair. It assumes ctrl_wr is one
// write per cycle.
module wdog_arm_fsm #(
    parameter int KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [KEY_W-1:0] key_in,
    input  logic             en_in,
    input  logic             mode_ok,
    output logic [1:0]       phase_o,
    output logic             svc_done_o,
    output logic             key_fault_o
);
    import wdog_pkg::*;

    wd_state_t state_q, state_d;

    // Decide the next state and the single-cycle pulses.
    always_comb begin
        state_d     = state_q;
        svc_done_o  = 1'b0;
        key_fault_o = 1'b0;
        if (ctrl_wr) begin
            case (state_q)
                ST_OFF: if (en_in && mode_ok)          state_d = ST_EN;
                ST_EN:  if (en_in && key_in == KEY_ARM) state_d = ST_PRE;
                ST_PRE: if (en_in && key_in == KEY_GO)  state_d = ST_ACT;
                ST_ACT: begin
                    if (key_in == KEY_ARM) state_d = ST_SVC;
                    else                   key_fault_o = 1'b1;
                end
                ST_SVC: begin
                    state_d = ST_ACT;
                    if (key_in == KEY_GO) svc_done_o  = 1'b1;
                    else                  key_fault_o = 1'b1;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Hold the state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    assign phase_o = phase_of(state_q);

endmodule

// File: rtl/wdog_keyed.sv
// Top level of the key-sequenced watchdog.
// Ties the configuration bank, counter and arming sequencer to the
// register bus. It raises the sticky reset request on a timeout or a
// key fault. It assumes BUS_W is 32 and CNT_W is a multiple of BUS_W.
module wdog_keyed #(
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wdog_rst_req
);
    import wdog_pkg::*;

    localparam int NW = CNT_W / BUS_W;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] period_q;
    logic [1:0]       mode_q;
    logic [1:0]       phase;
    logic             svc_done, key_fault;
    logic             ctrl_wr, cfg_open, active, req_q;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign cfg_open = (phase == PH_OFF);
    assign active   = (phase == PH_ACT);

    wdog_bank #(.BUS_W(BUS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .period_q (period_q),
        .mode_q   (mode_q)
    );

    wdog_tally #(.BUS_W(BUS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .run      (active && !req_q),
        .clr      (svc_done && !req_q),
        .count_q  (count_q)
    );

    wdog_arm_fsm #(.KEY_W(KEY_W), .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .key_in      (bus_wdata[KEY_LSB +: KEY_W]),
        .en_in       (bus_wdata[EN_BIT]),
        .mode_ok     (mode_q == MODE_WDOG),
        .phase_o     (phase),
        .svc_done_o  (svc_done),
        .key_fault_o (key_fault)
    );

    // Set the reset request on a timeout or a key fault and keep it set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (key_fault || (active && count_q == period_q))
            req_q <= 1'b1;
    end

    assign wdog_rst_req = req_q;

    // Select the register addressed on the bus for reading.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_MODE))
            bus_rdata[MODE_LSB +: 2] = mode_q;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[EN_BIT] = (phase != PH_OFF);
            bus_rdata[1:0]    = phase;
        end
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == ADDR_W'(OFS_CNT0 + 4 * w))
                bus_rdata = count_q[w*BUS_W +: BUS_W];
            if (bus_addr == ADDR_W'(OFS_PRD0 + 4 * w))
                bus_rdata = period_q[w*BUS_W +: BUS_W];
        end
    end

endmodule

// File: rtl/wdog_keyed_chk.sv
// Property checker for wdog_keyed, attached to it with a bind.
// Observes the bus, the phase, counter, period and mode, and the request.
module wdog_keyed_chk #(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [KEY_W-1:0]  key,
    input logic              req,
    input logic [1:0]        phase,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic [1:0]        mode
);
    import wdog_pkg::*;

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

    // R3
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OFF && mode != MODE_WDOG) |=> phase == PH_OFF);

    // R6
    enabled_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EN |=> (phase == PH_EN || phase == PH_PRE));

    // R7
    preactive_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_PRE |=> (phase == PH_PRE || phase == PH_ACT));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_ACT |=> phase == PH_ACT);

    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ACT && !bus_wr) |=> $stable(count));

    // R9
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT && count == period) |=> req);

    // R11
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT && ctrl_wr && key != KEY_ARM && key != KEY_GO) |=> req);

    // R12
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> req);

    // R12
    req_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $stable(count));

endmodule

bind wdog_keyed wdog_keyed_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .KEY_W(KEY_W),
    .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .key      (bus_wdata[wdog_pkg::KEY_LSB +: KEY_W]),
    .req      (wdog_rst_req),
    .phase    (phase),
    .count    (count_q),
    .period   (period_q),
    .mode     (mode_q)
);

// File: tb/test_wdog_keyed.sv
// Directed bench for wdog_keyed: one task per scenario, each checking itself.
module test_wdog_keyed;

    localparam logic [5:0] A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                           A_PHI = 6'h1C, A_MODE = 6'h24, A_CTRL = 6'h28;
    localparam logic [31:0] EN = 32'h0000_4000;
    localparam logic [31:0] K_ARM = 32'hA5C6_4000;
    localparam logic [31:0] K_GO  = 32'hDA7E_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wdog_keyed i_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_req(wdog_rst_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic arm(input logic [63:0] prd, input logic [63:0] cnt);
        do_reset();
        wr(A_PLO, prd[31:0]);
        wr(A_PHI, prd[63:32]);
        wr(A_CLO, cnt[31:0]);
        wr(A_CHI, cnt[63:32]);
        wr(A_MODE, 32'h8);
        wr(A_CTRL, EN);
        wr(A_CTRL, K_ARM);
        wr(A_CTRL, K_GO);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 req", wdog_rst_req, 0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_CLO, d);  chk("R1 cnt lo", d, 0);
        rd(A_PHI, d);  chk("R1 prd hi", d, 0);
        rd(A_MODE, d); chk("R1 mode", d, 0);
    endtask

    task automatic t_cfg_access();
        logic [31:0] d;
        do_reset();
        wr(A_CLO, 32'h11); wr(A_CHI, 32'h22); wr(A_PLO, 32'h33); wr(A_PHI, 32'h44);
        rd(A_CLO, d); chk("R2 cnt lo", d, 32'h11);
        rd(A_CHI, d); chk("R2 cnt hi", d, 32'h22);
        rd(A_PLO, d); chk("R2 prd lo", d, 32'h33);
        rd(A_PHI, d); chk("R2 prd hi", d, 32'h44);
        wr(A_MODE, 32'h8); wr(A_CTRL, EN);
        wr(A_CLO, 32'h99); wr(A_PLO, 32'h77);
        rd(A_CLO, d); chk("R2 cnt locked", d, 32'h11);
        rd(A_PLO, d); chk("R2 prd locked", d, 32'h33);
    endtask

    task automatic t_mode_gate();
        logic [31:0] d;
        do_reset();
        wr(A_MODE, 32'h4); wr(A_CTRL, EN);
        rd(A_CTRL, d); chk("R3 wrong mode no enable", d, 0);
        wr(A_MODE, 32'h8);
        rd(A_MODE, d); chk("R3 mode readback", d, 32'h8);
        wr(A_CTRL, EN); wr(A_MODE, 32'h0);
        rd(A_MODE, d); chk("R3 mode locked", d, 32'h8);
    endtask

    task automatic t_enable_sticky();
        logic [31:0] d;
        do_reset();
        wr(A_MODE, 32'h8); wr(A_CTRL, EN);
        rd(A_CTRL, d); chk("R4 enabled", d, 32'h4001);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d); chk("R5 enable kept", d, 32'h4001);
    endtask

    task automatic t_arm_steps();
        logic [31:0] d;
        do_reset();
        wr(A_PLO, 32'h1000); wr(A_MODE, 32'h8); wr(A_CTRL, EN);
        wr(A_CTRL, 32'h1111_4000);
        rd(A_CTRL, d); chk("R6 wrong key stays", d, 32'h4001);
        wr(A_CTRL, 32'hA5C6_0000);
        rd(A_CTRL, d); chk("R6 no enable bit stays", d, 32'h4001);
        wr(A_CTRL, K_ARM);
        rd(A_CTRL, d); chk("R6 pre-active", d, 32'h4002);
        wr(A_CTRL, 32'h5555_4000);
        rd(A_CTRL, d); chk("R7 wrong key stays", d, 32'h4002);
        wr(A_CTRL, K_GO);
        rd(A_CTRL, d); chk("R7 active", d, 32'h4003);
        chk("R7 no request", wdog_rst_req, 0);
    endtask

    task automatic t_count_run();
        logic [31:0] d;
        do_reset();
        wr(A_PLO, 32'h10); wr(A_PHI, 32'h5);
        wr(A_CLO, 32'hFFFF_FFFE);
        wr(A_MODE, 32'h8); wr(A_CTRL, EN); wr(A_CTRL, K_ARM);
        @(negedge clk); @(negedge clk);
        rd(A_CLO, d); chk("R8 holds in pre-active", d, 32'hFFFF_FFFE);
        wr(A_CTRL, K_GO);
        rd(A_CLO, d); chk("R8 first active edge", d, 32'hFFFF_FFFE);
        @(negedge clk);
        rd(A_CLO, d); chk("R8 step", d, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_CLO, d); chk("R8 carry lo", d, 32'h0);
        rd(A_CHI, d); chk("R8 carry hi", d, 32'h1);
        chk("R8 no request", wdog_rst_req, 0);
    endtask

    task automatic t_timeout();
        arm(64'd5, 64'd0);
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            chk($sformatf("R9 timeout edge %0d", j), wdog_rst_req, (j == 6));
        end
    endtask

    task automatic t_service();
        logic [31:0] d;
        arm(64'h40, 64'd0);
        repeat (10) @(negedge clk);
        wr(A_CTRL, K_ARM);
        chk("R10 after first key", wdog_rst_req, 0);
        wr(A_CTRL, K_GO);
        rd(A_CLO, d); chk("R10 cleared", d, 0);
        @(negedge clk);
        rd(A_CLO, d); chk("R10 restarted", d, 1);
        chk("R10 no request", wdog_rst_req, 0);
    endtask

    task automatic t_bad_key();
        arm(64'h1_0000, 64'd0);
        wr(A_CTRL, EN);
        chk("R11 zero key", wdog_rst_req, 1);
        arm(64'h1_0000, 64'd0);
        wr(A_CTRL, K_ARM);
        chk("R11 before bad second", wdog_rst_req, 0);
        wr(A_CTRL, 32'h1234_4000);
        chk("R11 bad second key", wdog_rst_req, 1);
        arm(64'h1_0000, 64'd0);
        wr(A_CTRL, K_GO);
        chk("R11 second key first", wdog_rst_req, 1);
    endtask

    task automatic t_sticky();
        logic [31:0] d0, d1;
        arm(64'h1_0000, 64'd0);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h0BAD_4000);
        rd(A_CLO, d0);
        repeat (5) @(negedge clk);
        rd(A_CLO, d1);
        chk("R12 counter frozen", d1, d0);
        chk("R12 request held", wdog_rst_req, 1);
        wr(A_CTRL, K_ARM); wr(A_CTRL, K_GO);
        chk("R12 service does not clear", wdog_rst_req, 1);
        do_reset();
        chk("R12 reset clears", wdog_rst_req, 0);
    endtask

    initial begin
        t_reset();
        t_cfg_access();
        t_mode_gate();
        t_enable_sticky();
        t_arm_steps();
        t_count_run();
        t_timeout();
        t_service();
        t_bad_key();
        t_sticky();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule